// File: doc/BRIEF.md
# Shift-Scaled Four-Channel PWM Timer

This block is a pulse-width modulation timer with several output channels that share one free-running counter. The counter is wide enough to hold the comparator width plus the largest shift. A 4-bit scale field picks how far the counter is shifted right before it reaches the comparators. The period is therefore a power of two, 2^(16+scale) clock ticks, and there is no terminal-count register. Each channel holds a 16-bit compare value and drives an active-low output. That output is low while the scaled count is below the compare value.

Software reaches the block through a single-cycle register port. One strobe with a write flag, an address and data gives access to the configuration word, the raw counter, the scaled counter and the compare registers. Read data is combinational from the address. Compare writes take effect on the next clock with no shadow copy, so a period in flight can mix old and new settings. The outputs are inverted only. A full 100% duty cycle cannot be produced, because the top scaled value never lies below any 16-bit compare value.

Top module: `shift_pwm_timer`

## Requirements
- R1: After reset the configuration word, the raw counter and every compare register read 0, and every output is high.
- R2: The register map is: configuration at 0x00 (32 bits, read/write), raw counter at 0x08 (read/write), scaled counter at 0x10 (read-only), and compare register n at 0x20 + 4*n (the low 16 bits are used). Any other address reads 0.
- R3: The raw counter is 31 bits wide. It advances by one on every clock while configuration bit 12 (run) is set and holds while that bit is clear. A write to 0x08 loads it, and the load takes priority over the increment.
- R4: The raw counter wraps from 0x7FFFFFFF to 0.
- R5: The scaled counter equals the raw counter shifted right by configuration bits [3:0], truncated to 16 bits.
- R6: While run is set, output n is low exactly when the scaled count is below compare n. Otherwise it is high.
- R7: A compare value of 0 never drives its output low. When the scaled count is 0xFFFF every output is high, even with compare 0xFFFF.
- R8: While run is clear, every output is high, whatever the compare values are.
- R9: Configuration bits 8, 9, 10, 13, 16, 24 and 28 are stored and read back, but they change neither the counting nor the outputs.
- R10: A compare write changes the output from the next clock on, without waiting for a period boundary.
- R11: At scale 0 the period is 65536 clocks, and during one period channel n is low for exactly compare-n clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| pwm_n | output | 4 | Active-low channel outputs |

## Verification
The hardest situations to reach from the ports are the counter wrap and the large-scale comparisons. Reaching either by free running would take billions of clocks. The stimulus stops the counter, loads arbitrary raw values through the counter register, and then runs a few cycles. That puts the wrap, scaled values near 0xFFFF and every scale setting within reach. One full 65536-clock period at scale 0 measures the duty cycle directly.

// File: rtl/spt_pkg.sv
package spt_pkg;
   localparam logic [7:0] OFF_CFG    = 8'h00;
   localparam logic [7:0] OFF_RAW    = 8'h08;
   localparam logic [7:0] OFF_SCALED = 8'h10;
   localparam logic [7:0] OFF_CMP0   = 8'h20;
   localparam int         CMP_STRIDE = 4;
   localparam int         RUN_BIT    = 12;

   function automatic logic [7:0] cmp_offset(input int idx);
      return OFF_CMP0 + 8'(idx * CMP_STRIDE);
   endfunction
endpackage

// File: rtl/spt_counter.sv
module spt_counter #(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (load)   count <= load_val;
      else if (run)    count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/spt_scaler.sv
module spt_scaler #(
   parameter int CNT_W    = 31,
   parameter int CMP_W    = 16,
   parameter int SCALE_W  = 4,
   parameter bit MUX_TREE = 1'b1
) (
   input  logic [CNT_W-1:0]   count,
   input  logic [SCALE_W-1:0] scale,
   output logic [CMP_W-1:0]   scaled
);
   generate
      if (MUX_TREE) begin : g_tree
         logic [CNT_W-1:0] stage [SCALE_W+1];
         assign stage[0] = count;
         for (genvar s = 0; s < SCALE_W; s++) begin : g_stage
            assign stage[s+1] = scale[s] ? (stage[s] >> (1 << s)) : stage[s];
         end
         assign scaled = stage[SCALE_W][CMP_W-1:0];
      end else begin : g_op
         logic [CNT_W-1:0] shifted;
         assign shifted = count >> scale;
         assign scaled  = shifted[CMP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/spt_channel.sv
module spt_channel #(
   parameter int CMP_W = 16
) (
   input  logic             run,
   input  logic [CMP_W-1:0] scaled,
   input  logic [CMP_W-1:0] cmp,
   output logic             out_n
);
   logic active;
   assign active = run && (scaled < cmp);
   assign out_n  = ~active;
endmodule

// File: rtl/spt_regs.sv
module spt_regs
   import spt_pkg::*;
#(
   parameter int NCHAN   = 4,
   parameter int CMP_W   = 16,
   parameter int CNT_W   = 31,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic                   bus_write,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic [CNT_W-1:0]       count,
   input  logic [CMP_W-1:0]       scaled,
   output logic [DATA_W-1:0]      cfg,
   output logic [NCHAN*CMP_W-1:0] cmp_flat,
   output logic                   cnt_load,
   output logic [CNT_W-1:0]       cnt_load_val,
   output logic [DATA_W-1:0]      rdata
);
   logic wr;
   assign wr           = bus_valid && bus_write;
   assign cnt_load     = wr && (bus_addr == ADDR_W'(OFF_RAW));
   assign cnt_load_val = bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cfg <= '0;
      else if (wr && bus_addr == ADDR_W'(OFF_CFG))  cfg <= bus_wdata;
   end

   generate
      for (genvar ch = 0; ch < NCHAN; ch++) begin : g_cmp
         logic hit;
         assign hit = wr && (bus_addr == ADDR_W'(cmp_offset(ch)));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cmp_flat[ch*CMP_W +: CMP_W] <= '0;
            else if (hit) cmp_flat[ch*CMP_W +: CMP_W] <= bus_wdata[CMP_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CFG))         rdata = cfg;
      else if (bus_addr == ADDR_W'(OFF_RAW))    rdata = DATA_W'(count);
      else if (bus_addr == ADDR_W'(OFF_SCALED)) rdata = DATA_W'(scaled);
      else begin
         for (int ch = 0; ch < NCHAN; ch++) begin
            if (bus_addr == ADDR_W'(cmp_offset(ch)))
               rdata = DATA_W'(cmp_flat[ch*CMP_W +: CMP_W]);
         end
      end
   end
endmodule

// File: rtl/shift_pwm_timer.sv
module shift_pwm_timer
   import spt_pkg::*;
#(
   parameter int NCHAN    = 4,
   parameter int CMP_W    = 16,
   parameter int SCALE_W  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit MUX_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NCHAN-1:0]  pwm_n
);
   localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

   generate
      if (CNT_W > DATA_W) begin : g_bad_width
         $error("counter wider than data bus");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("address too narrow for register map");
      end
      if (NCHAN < 1 || NCHAN > 56) begin : g_bad_chan
         $error("channel count out of range");
      end
      if (RUN_BIT >= DATA_W) begin : g_bad_run
         $error("run bit outside configuration word");
      end
   endgenerate

   logic [DATA_W-1:0]      cfg;
   logic [NCHAN*CMP_W-1:0] cmp_flat;
   logic                   cnt_load;
   logic [CNT_W-1:0]       cnt_load_val;
   logic [CNT_W-1:0]       raw_cnt;
   logic [CMP_W-1:0]       scaled_cnt;
   logic                   run;

   assign run = cfg[RUN_BIT];

   spt_regs #(
      .NCHAN(NCHAN), .CMP_W(CMP_W), .CNT_W(CNT_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .count(raw_cnt), .scaled(scaled_cnt),
      .cfg(cfg), .cmp_flat(cmp_flat),
      .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
      .rdata(bus_rdata)
   );

   spt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run),
      .load(cnt_load), .load_val(cnt_load_val), .count(raw_cnt)
   );

   spt_scaler #(
      .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W), .MUX_TREE(MUX_TREE)
   ) u_scale (
      .count(raw_cnt), .scale(cfg[SCALE_W-1:0]), .scaled(scaled_cnt)
   );

   generate
      for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
         spt_channel #(.CMP_W(CMP_W)) u_ch (
            .run(run), .scaled(scaled_cnt),
            .cmp(cmp_flat[ch*CMP_W +: CMP_W]), .out_n(pwm_n[ch])
         );
      end
   endgenerate
endmodule

// File: rtl/shift_pwm_timer_chk.sv
module shift_pwm_timer_chk #(
   parameter int NCHAN = 4,
   parameter int CMP_W = 16,
   parameter int CNT_W = 31
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   run,
   input logic                   load,
   input logic [CNT_W-1:0]       count,
   input logic [CMP_W-1:0]       scaled,
   input logic [NCHAN*CMP_W-1:0] cmp_flat,
   input logic [NCHAN-1:0]       pwm_n
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> count == $past(count) + CNT_W'(1)); // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count)); // R3
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> pwm_n == '1); // R8
   AST_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scaled == '1) |-> pwm_n == '1); // R7
   generate
      for (genvar ch = 0; ch < NCHAN; ch++) begin : g_zero
         AST_ZERO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_flat[ch*CMP_W +: CMP_W] == '0) |-> pwm_n[ch]); // R7
      end
   endgenerate
endmodule

bind shift_pwm_timer shift_pwm_timer_chk #(
   .NCHAN(NCHAN), .CMP_W(CMP_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .load(cnt_load),
   .count(raw_cnt), .scaled(scaled_cnt), .cmp_flat(cmp_flat), .pwm_n(pwm_n)
);

// File: tb/shift_pwm_timer_test.sv
module shift_pwm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_n;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   localparam logic [31:0] RUN      = 32'h0000_1000;
   localparam logic [31:0] IGNORED  = 32'h1101_2700;

   always #10 clk = ~clk;

   shift_pwm_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_n(pwm_n)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [15:0] scale_of(input logic [30:0] c, input int s);
      logic [30:0] t;
      t = c >> s;
      return t[15:0];
   endfunction

   function automatic logic [3:0] exp_out(input bit on, input logic [15:0] sc,
                                          input logic [15:0] c [4]);
      logic [3:0] o;
      for (int i = 0; i < 4; i++) o[i] = !(on && sc < c[i]);
      return o;
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      logic [15:0] cmpv [4];
      logic [30:0] start;
      int          sc, n, lows;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(8'h00, r); check("R1 cfg", r, 0);
      rd(8'h08, r); check("R1 raw", r, 0);
      for (int i = 0; i < 4; i++) begin
         rd(8'h20 + 8'(4*i), r); check("R1 cmp", r, 0);
      end
      check("R1 outputs", 32'(pwm_n), 32'hF);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h08, r); check("R3 hold while stopped", r, 0);

      // R2 map and unmapped read
      wr(8'h24, 32'hABCD_5678); rd(8'h24, r); check("R2 cmp1 low 16 bits", r, 32'h5678);
      rd(8'h04, r); check("R2 unmapped", r, 0);
      rd(8'h30, r); check("R2 unmapped past cmp", r, 0);
      wr(8'h10, 32'h1234); rd(8'h10, r); check("R2 scaled read-only", r, 0);

      // R8 stopped outputs high with nonzero compares
      for (int i = 0; i < 4; i++) begin cmpv[i] = 16'hFFFF; wr(8'h20 + 8'(4*i), 32'hFFFF); end
      check("R8 idle high", 32'(pwm_n), 32'hF);

      // R4 wrap
      wr(8'h08, 32'h7FFF_FFFF);
      rd(8'h08, r); check("R3 load", r, 32'h7FFF_FFFF);
      wr(8'h00, RUN);
      @(negedge clk);
      rd(8'h08, r); check("R4 wrap", r, 0);
      wr(8'h00, 32'h0);

      // R9 ignored bits with run clear: counter holds, outputs high
      wr(8'h08, 32'h100);
      wr(8'h00, IGNORED | 32'h3);
      rd(8'h00, r); check("R9 readback", r, IGNORED | 32'h3);
      repeat (5) @(negedge clk);
      rd(8'h08, r); check("R9 no run from other bits", r, 32'h100);
      check("R9 outputs idle", 32'(pwm_n), 32'hF);

      // R7 top scaled value, compare 0xFFFF
      wr(8'h08, 32'h000F_FFF0);
      wr(8'h00, IGNORED | RUN | 32'h4);
      rd(8'h10, r); check("R5 scaled top", r, 32'hFFFF);
      check("R7 no full duty", 32'(pwm_n), 32'hF);
      wr(8'h00, 32'h0);

      // R7 zero compare, R10 immediate compare write
      wr(8'h08, 32'h0000_0005);
      for (int i = 0; i < 4; i++) begin cmpv[i] = 16'h0; wr(8'h20 + 8'(4*i), 0); end
      wr(8'h00, RUN | IGNORED);
      check("R7 zero compare", 32'(pwm_n), 32'hF);
      wr(8'h00, 32'h0);
      wr(8'h28, 32'h0000_0100);
      wr(8'h00, RUN);
      check("R10 immediate compare", 32'(pwm_n), 32'hB);
      wr(8'h28, 32'h0000_0001);
      check("R10 immediate compare lowered", 32'(pwm_n), 32'hF);
      wr(8'h00, 32'h0);

      // random: R5, R6, R3
      for (int it = 0; it < 60; it++) begin
         sc    = $urandom_range(0, 15);
         start = 31'($urandom);
         wr(8'h00, 32'(sc));
         wr(8'h08, 32'(start));
         for (int i = 0; i < 4; i++) begin
            case ($urandom_range(0, 3))
               0: cmpv[i] = scale_of(start, sc);
               1: cmpv[i] = scale_of(start, sc) + 16'd1;
               default: cmpv[i] = 16'($urandom);
            endcase
            wr(8'h20 + 8'(4*i), 32'(cmpv[i]));
         end
         rd(8'h10, r); check("R5 scaled", r, 32'(scale_of(start, sc)));
         check("R8 stopped outputs", 32'(pwm_n), 32'hF);
         wr(8'h00, RUN | 32'(sc));
         n = $urandom_range(1, 20);
         repeat (n) @(negedge clk);
         start = start + 31'(n);
         rd(8'h08, r); check("R3 count advance", r, 32'(start));
         rd(8'h10, r); check("R5 scaled running", r, 32'(scale_of(start, sc)));
         check("R6 outputs", 32'(pwm_n), 32'(exp_out(1'b1, scale_of(start, sc), cmpv)));
      end

      // R11 full period at scale 0
      wr(8'h00, 32'h0);
      wr(8'h08, 32'h0);
      wr(8'h24, 32'h1234);
      wr(8'h00, RUN);
      lows = 0;
      for (int k = 0; k < 65536; k++) begin
         if (!pwm_n[1]) lows++;
         @(negedge clk);
      end
      check("R11 low time", 32'(lows), 32'h1234);
      rd(8'h08, r); check("R11 period length", r, 32'h10000);
      rd(8'h10, r); check("R11 scaled restart", r, 0);
      check("R11 next period low", 32'(pwm_n[1]), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule